// File: doc/BRIEF.md
# SCSI DMA Adapter Control and Status Registers

This block is the register front end of a bus-mastering SCSI adapter. It sits between a host bus, an 8-bit SCSI protocol controller and a DMA engine with a data FIFO. It drives two active-low reset lines, a transfer direction line and a DMA enable line. It holds the 32-bit DMA address, the 32-bit DMA count and the 32-bit FIFO count, each written as two 16-bit halves, plus a 16-bit interrupt vector and address-modifier word. It latches completion and error events from the DMA engine and produces one host interrupt. The FIFO storage and the bus mastering are outside the block: the FIFO is seen only through a not-empty flag, and the DMA engine only through event pulses.

The adapter has three hardware quirks. The DMA enable line also gates the protocol controller's interrupt, so software must enable DMA even while idle if it wants to hear from the controller. While DMA is enabled, the host cannot reach the controller's registers. The controller's interrupt is also masked whenever the FIFO holds data or the FIFO count is nonzero.

The host sees a 2 KB space, addressed in 16-bit halfwords through a 10-bit index. Index 0x000 to 0x007 is the controller window. Index 0x200 plus k, for k from 0 to 7, is adapter register k. Every other index reads 0 and ignores writes. Read data is combinational and valid during a read access.

Top module: `scsi_dma_csr`

## Requirements
- R1: After reset every adapter register reads 0x0000. Both reset outputs are low, `dma_en`, `dir_send` and `irq` are low, and the address and count outputs are zero.
- R2: Register 0 is the control word: bit 0 is the FIFO reset and bit 1 is the SCSI reset. Both are active low: writing 0 drives the matching output low, and writing 1 releases it.
- R3: Register pairs (1 high, 2 low), (3 high, 4 low) and (5 high, 6 low) hold the DMA address, the DMA count and the FIFO count. Each half can be written and read back on its own, and the full 32-bit value appears on `dma_addr`, `dma_count` and `fifo_count`.
- R4: A write to either FIFO count half also sets the whole DMA count to zero, taking effect at the same clock edge as the write.
- R5: While control bit 3 (DMA enable) is 0, an access to window index k asserts `chip_sel` with `chip_addr`=k. A write also asserts `chip_we` and drives `chip_wdata` from data bits 7:0. A read returns {8'h00, `chip_rdata`}.
- R6: While DMA enable is 1, window accesses leave `chip_sel` and `chip_we` low, and window reads return 0x0000.
- R7: Control word bits 11:8 are read-only status: bit 8 is controller interrupt pending, bit 9 is DMA interrupt pending, bit 10 is DMA conflict and bit 11 is DMA bus error. Writes to them have no effect.
- R8: `dma_done`, `dma_conflict` and `dma_buserr` pulses set sticky flags. A set conflict or bus error flag also makes bit 9 read as 1.
- R9: While the FIFO reset is held (bit 0 = 0), the three sticky flags are cleared and new event pulses are ignored.
- R10: Status bit 8 equals `chip_irq` only when `fifo_not_empty` is 0 and the FIFO count is zero; otherwise it is 0.
- R11: `irq` = bit2 AND (bit9 OR (bit3 AND bit8)), where bit 2 is interrupt enable. The controller interrupt therefore reaches `irq` only with DMA enabled, even when no transfer is set up.
- R12: Control bit 4 drives `dir_send` (1 = send to SCSI). Register 7 holds the vector/modifier word, which reads back and appears on `vec_am`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 10 | Halfword index into the 2 KB space |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| chip_sel | output | 1 | Protocol controller select |
| chip_we | output | 1 | Protocol controller write strobe |
| chip_addr | output | 3 | Protocol controller register index |
| chip_wdata | output | 8 | Protocol controller write data |
| chip_rdata | input | 8 | Protocol controller read data |
| chip_irq | input | 1 | Protocol controller interrupt request |
| dma_done | input | 1 | DMA completion event pulse |
| dma_conflict | input | 1 | DMA conflict event pulse |
| dma_buserr | input | 1 | DMA bus error event pulse |
| fifo_not_empty | input | 1 | FIFO holds data |
| fifo_rst_n | output | 1 | FIFO reset, active low |
| scsi_rst_n | output | 1 | SCSI bus reset, active low |
| dma_en | output | 1 | DMA engine enable |
| dir_send | output | 1 | Transfer direction, 1 = send |
| dma_addr | output | 32 | DMA address |
| dma_count | output | 32 | DMA transfer count |
| fifo_count | output | 32 | FIFO count |
| vec_am | output | 16 | Interrupt vector and address modifier |
| irq | output | 1 | Host interrupt |

## Verification
The bench runs the interrupt path over all 64 combinations of interrupt enable, DMA enable, controller request, FIFO not-empty, FIFO count nonzero and DMA pending. A design that ignored the DMA enable gate would pass the controller interrupt through while idle. A design that skipped FIFO suppression would raise `irq` while data is still buffered. It drives the controller window with DMA both enabled and disabled; a design that failed to block would emit a stray `chip_sel` or return live controller data. It writes the DMA count and then a FIFO count half, which shows whether a stale count survives. It sends event pulses while the FIFO reset is held, which catches flags that latch during reset or are not folded into the DMA pending bit.

// File: rtl/scsi_dma_csr_pkg.sv
package scsi_dma_csr_pkg;

    localparam int HALF_W  = 16;
    localparam int WIDE_W  = 2 * HALF_W;
    localparam int CHIP_DW = 8;
    localparam int CTRL_W  = 5;
    localparam int STAT_W  = 4;

    // Three split wide registers, numbered in pair order.
    localparam int PAIRS      = 3;
    localparam int PAIR_DADDR = 0;
    localparam int PAIR_DCNT  = 1;
    localparam int PAIR_FCNT  = 2;

    typedef enum logic [3:0] {
        AREG_CTRL     = 4'd0,
        AREG_DADDR_HI = 4'd1,
        AREG_DADDR_LO = 4'd2,
        AREG_DCNT_HI  = 4'd3,
        AREG_DCNT_LO  = 4'd4,
        AREG_FCNT_HI  = 4'd5,
        AREG_FCNT_LO  = 4'd6,
        AREG_VECAM    = 4'd7
    } areg_e;

    // Writable control field, LSB first: fifo reset, scsi reset, irq enable,
    // dma enable, direction.
    typedef struct packed {
        logic dir_send;
        logic dma_en;
        logic irq_en;
        logic scsi_rst_n;
        logic fifo_rst_n;
    } ctrl_t;

    // Read-only status field at bits 11:8.
    typedef struct packed {
        logic bus_err;
        logic conflict;
        logic dma_pend;
        logic chip_pend;
    } stat_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CHIP,
        ACC_ADAPTER
    } acc_e;

    function automatic logic [HALF_W-1:0] csr_word(input ctrl_t c, input stat_t s);
        return {4'b0000, s, 3'b000, c};
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [HALF_W-1:0] w);
        return ctrl_t'(w[CTRL_W-1:0]);
    endfunction

    function automatic int unsigned hi_index(input int unsigned pair);
        return 1 + 2 * pair;
    endfunction

    function automatic int unsigned lo_index(input int unsigned pair);
        return 2 + 2 * pair;
    endfunction

endpackage

// File: rtl/scsi_dma_csr_decode.sv
module scsi_dma_csr_decode
    import scsi_dma_csr_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int CHIP_AW = 3,
    parameter int REG_IW  = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    output acc_e               kind,
    output logic [CHIP_AW-1:0] chip_idx,
    output logic [REG_IW-1:0]  reg_idx
);
    // Controller window sits at the bottom, adapter bank in the upper half.
    localparam int WIN_TOP = ADDR_W - 1;

    always_comb begin
        chip_idx = addr[CHIP_AW-1:0];
        reg_idx  = addr[REG_IW-1:0];
        if (addr[WIN_TOP:CHIP_AW] == '0) begin
            kind = ACC_CHIP;
        end else if (addr[WIN_TOP] && (addr[WIN_TOP-1:REG_IW] == '0)) begin
            kind = ACC_ADAPTER;
        end else begin
            kind = ACC_NONE;
        end
    end
endmodule

// File: rtl/scsi_dma_csr_regs.sv
module scsi_dma_csr_regs
    import scsi_dma_csr_pkg::*;
#(
    parameter int REG_IW = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [REG_IW-1:0]             idx,
    input  logic [HALF_W-1:0]             wdata,
    output ctrl_t                         ctrl,
    output logic [PAIRS-1:0][WIDE_W-1:0]  wide,
    output logic [HALF_W-1:0]             vec_am
);
    localparam logic [REG_IW-1:0] CTRL_IDX  = REG_IW'(AREG_CTRL);
    localparam logic [REG_IW-1:0] VECAM_IDX = REG_IW'(AREG_VECAM);
    localparam logic [REG_IW-1:0] FHI_IDX   = REG_IW'(hi_index(PAIR_FCNT));
    localparam logic [REG_IW-1:0] FLO_IDX   = REG_IW'(lo_index(PAIR_FCNT));

    logic fcnt_wr;
    assign fcnt_wr = wr_en && ((idx == FHI_IDX) || (idx == FLO_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && (idx == CTRL_IDX)) begin
            ctrl <= ctrl_from_word(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_am <= '0;
        end else if (wr_en && (idx == VECAM_IDX)) begin
            vec_am <= wdata;
        end
    end

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        localparam logic [REG_IW-1:0] HI_IDX = REG_IW'(hi_index(p));
        localparam logic [REG_IW-1:0] LO_IDX = REG_IW'(lo_index(p));
        localparam bit CLEARED_BY_FCNT = (p == PAIR_DCNT);

        logic [WIDE_W-1:0] val_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else if (wr_en && (idx == HI_IDX)) begin
                val_q[WIDE_W-1:HALF_W] <= wdata;
            end else if (wr_en && (idx == LO_IDX)) begin
                val_q[HALF_W-1:0] <= wdata;
            end else if (CLEARED_BY_FCNT && fcnt_wr) begin
                val_q <= '0;
            end
        end

        assign wide[p] = val_q;
    end

    // R4: any FIFO count write leaves the DMA count at zero
    assert_fcnt_clears_dcnt_R4: assert property (
        @(posedge clk) disable iff (rst)
        fcnt_wr |=> (wide[PAIR_DCNT] == '0)
    );

    // R2: control changes only through a control write
    assert_ctrl_only_by_write_R2: assert property (
        @(posedge clk) disable iff (rst)
        !(wr_en && (idx == CTRL_IDX)) |=> $stable(ctrl)
    );
endmodule

// File: rtl/scsi_dma_csr_status.sv
module scsi_dma_csr_status
    import scsi_dma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [WIDE_W-1:0] fifo_cnt,
    input  logic              fifo_not_empty,
    input  logic              chip_irq,
    input  logic              dma_done,
    input  logic              dma_conflict,
    input  logic              dma_buserr,
    output stat_t             stat,
    output logic              irq
);
    logic done_q, conf_q, berr_q;
    logic chip_quiet;

    // Sticky event flags, wiped and deaf while the FIFO reset is held.
    always_ff @(posedge clk) begin
        if (rst || !ctrl.fifo_rst_n) begin
            done_q <= 1'b0;
            conf_q <= 1'b0;
            berr_q <= 1'b0;
        end else begin
            done_q <= done_q | dma_done;
            conf_q <= conf_q | dma_conflict;
            berr_q <= berr_q | dma_buserr;
        end
    end

    assign chip_quiet = fifo_not_empty || (fifo_cnt != '0);

    always_comb begin
        stat.chip_pend = chip_irq && !chip_quiet;
        stat.dma_pend  = done_q || conf_q || berr_q;
        stat.conflict  = conf_q;
        stat.bus_err   = berr_q;
    end

    assign irq = ctrl.irq_en && (stat.dma_pend || (ctrl.dma_en && stat.chip_pend));

    // R9: a held FIFO reset leaves every flag clear one cycle later
    assert_flags_clear_in_reset_R9: assert property (
        @(posedge clk) disable iff (rst)
        !ctrl.fifo_rst_n |=> (!conf_q && !berr_q && !done_q)
    );

    // R8: an error flag is always reported as a DMA interrupt
    assert_err_implies_dma_pend_R8: assert property (
        @(posedge clk) disable iff (rst)
        (conf_q || berr_q) |-> stat.dma_pend
    );

    // R10: buffered data masks the controller interrupt
    assert_fifo_masks_chip_R10: assert property (
        @(posedge clk) disable iff (rst)
        fifo_not_empty |-> !stat.chip_pend
    );

    // R11: no host interrupt without the enable, no controller path without DMA
    assert_irq_needs_enable_R11: assert property (
        @(posedge clk) disable iff (rst)
        !ctrl.irq_en |-> !irq
    );

    assert_chip_path_needs_dma_R11: assert property (
        @(posedge clk) disable iff (rst)
        (irq && !stat.dma_pend) |-> (ctrl.dma_en && chip_irq)
    );
endmodule

// File: rtl/scsi_dma_csr_chip.sv
module scsi_dma_csr_chip
    import scsi_dma_csr_pkg::*;
#(
    parameter int CHIP_AW = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_req,
    input  logic               host_we,
    input  logic               win_hit,
    input  logic               dma_en,
    input  logic [CHIP_AW-1:0] idx,
    input  logic [CHIP_DW-1:0] wdata,
    input  logic [CHIP_DW-1:0] chip_rdata,
    output logic               chip_sel,
    output logic               chip_we,
    output logic [CHIP_AW-1:0] chip_addr,
    output logic [CHIP_DW-1:0] chip_wdata,
    output logic [HALF_W-1:0]  rd_word
);
    logic granted;

    // Host reaches the controller only while the DMA engine is off.
    assign granted    = host_req && win_hit && !dma_en;
    assign chip_sel   = granted;
    assign chip_we    = granted && host_we;
    assign chip_addr  = idx;
    assign chip_wdata = wdata;
    assign rd_word    = granted ? {{(HALF_W-CHIP_DW){1'b0}}, chip_rdata} : '0;

    // R6: no controller cycle while DMA is enabled
    assert_chip_blocked_R6: assert property (
        @(posedge clk) disable iff (rst)
        dma_en |-> (!chip_sel && !chip_we)
    );

    // R5: a controller write strobe comes only with a select
    assert_we_with_sel_R5: assert property (
        @(posedge clk) disable iff (rst)
        chip_we |-> chip_sel
    );
endmodule

// File: rtl/scsi_dma_csr.sv
module scsi_dma_csr
    import scsi_dma_csr_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int CHIP_AW = 3,
    parameter int REG_IW  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [15:0]        host_wdata,
    output logic [15:0]        host_rdata,
    output logic               chip_sel,
    output logic               chip_we,
    output logic [CHIP_AW-1:0] chip_addr,
    output logic [7:0]         chip_wdata,
    input  logic [7:0]         chip_rdata,
    input  logic               chip_irq,
    input  logic               dma_done,
    input  logic               dma_conflict,
    input  logic               dma_buserr,
    input  logic               fifo_not_empty,
    output logic               fifo_rst_n,
    output logic               scsi_rst_n,
    output logic               dma_en,
    output logic               dir_send,
    output logic [31:0]        dma_addr,
    output logic [31:0]        dma_count,
    output logic [31:0]        fifo_count,
    output logic [15:0]        vec_am,
    output logic               irq
);
    acc_e                        kind;
    logic [CHIP_AW-1:0]          chip_idx;
    logic [REG_IW-1:0]           reg_idx;
    ctrl_t                       ctrl;
    stat_t                       stat;
    logic [PAIRS-1:0][WIDE_W-1:0] wide;
    logic [HALF_W-1:0]           chip_word;
    logic [HALF_W-1:0]           reg_word;
    logic                        reg_wr;

    scsi_dma_csr_decode #(
        .ADDR_W (ADDR_W),
        .CHIP_AW(CHIP_AW),
        .REG_IW (REG_IW)
    ) u_decode (
        .addr    (host_addr),
        .kind    (kind),
        .chip_idx(chip_idx),
        .reg_idx (reg_idx)
    );

    assign reg_wr = host_req && host_we && (kind == ACC_ADAPTER);

    scsi_dma_csr_regs #(
        .REG_IW(REG_IW)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .idx   (reg_idx),
        .wdata (host_wdata),
        .ctrl  (ctrl),
        .wide  (wide),
        .vec_am(vec_am)
    );

    scsi_dma_csr_status u_status (
        .clk           (clk),
        .rst           (rst),
        .ctrl          (ctrl),
        .fifo_cnt      (wide[PAIR_FCNT]),
        .fifo_not_empty(fifo_not_empty),
        .chip_irq      (chip_irq),
        .dma_done      (dma_done),
        .dma_conflict  (dma_conflict),
        .dma_buserr    (dma_buserr),
        .stat          (stat),
        .irq           (irq)
    );

    scsi_dma_csr_chip #(
        .CHIP_AW(CHIP_AW)
    ) u_chip (
        .clk       (clk),
        .rst       (rst),
        .host_req  (host_req),
        .host_we   (host_we),
        .win_hit   (kind == ACC_CHIP),
        .dma_en    (ctrl.dma_en),
        .idx       (chip_idx),
        .wdata     (host_wdata[CHIP_DW-1:0]),
        .chip_rdata(chip_rdata),
        .chip_sel  (chip_sel),
        .chip_we   (chip_we),
        .chip_addr (chip_addr),
        .chip_wdata(chip_wdata),
        .rd_word   (chip_word)
    );

    always_comb begin
        case (areg_e'(reg_idx))
            AREG_CTRL:     reg_word = csr_word(ctrl, stat);
            AREG_DADDR_HI: reg_word = wide[PAIR_DADDR][WIDE_W-1:HALF_W];
            AREG_DADDR_LO: reg_word = wide[PAIR_DADDR][HALF_W-1:0];
            AREG_DCNT_HI:  reg_word = wide[PAIR_DCNT][WIDE_W-1:HALF_W];
            AREG_DCNT_LO:  reg_word = wide[PAIR_DCNT][HALF_W-1:0];
            AREG_FCNT_HI:  reg_word = wide[PAIR_FCNT][WIDE_W-1:HALF_W];
            AREG_FCNT_LO:  reg_word = wide[PAIR_FCNT][HALF_W-1:0];
            AREG_VECAM:    reg_word = vec_am;
            default:       reg_word = '0;
        endcase
    end

    always_comb begin
        case (kind)
            ACC_CHIP:    host_rdata = chip_word;
            ACC_ADAPTER: host_rdata = reg_word;
            default:     host_rdata = '0;
        endcase
    end

    assign fifo_rst_n = ctrl.fifo_rst_n;
    assign scsi_rst_n = ctrl.scsi_rst_n;
    assign dma_en     = ctrl.dma_en;
    assign dir_send   = ctrl.dir_send;
    assign dma_addr   = wide[PAIR_DADDR];
    assign dma_count  = wide[PAIR_DCNT];
    assign fifo_count = wide[PAIR_FCNT];

    // R1: reset drives every reset line active and the interrupt low
    assert_reset_state_R1: assert property (
        @(posedge clk)
        rst |=> (!fifo_rst_n && !scsi_rst_n && !dma_en && !irq)
    );
endmodule

// File: tb/test_scsi_dma_csr.sv
module test_scsi_dma_csr;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        chip_sel, chip_we;
    logic [2:0]  chip_addr;
    logic [7:0]  chip_wdata;
    logic [7:0]  chip_rdata = '0;
    logic        chip_irq = 1'b0;
    logic        dma_done = 1'b0, dma_conflict = 1'b0, dma_buserr = 1'b0;
    logic        fifo_not_empty = 1'b0;
    logic        fifo_rst_n, scsi_rst_n, dma_en, dir_send, irq;
    logic [31:0] dma_addr, dma_count, fifo_count;
    logic [15:0] vec_am;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [9:0] BASE = 10'h200;

    always #2 clk = ~clk;

    scsi_dma_csr i_scsi_dma_csr (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .chip_sel(chip_sel), .chip_we(chip_we), .chip_addr(chip_addr),
        .chip_wdata(chip_wdata), .chip_rdata(chip_rdata), .chip_irq(chip_irq),
        .dma_done(dma_done), .dma_conflict(dma_conflict), .dma_buserr(dma_buserr),
        .fifo_not_empty(fifo_not_empty),
        .fifo_rst_n(fifo_rst_n), .scsi_rst_n(scsi_rst_n), .dma_en(dma_en),
        .dir_send(dir_send), .dma_addr(dma_addr), .dma_count(dma_count),
        .fifo_count(fifo_count), .vec_am(vec_am), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [15:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [15:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = a;
        #1 d = host_rdata;
        host_req = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) dma_done = 1'b1;
        else if (which == 1) dma_conflict = 1'b1;
        else dma_buserr = 1'b1;
        @(negedge clk);
        dma_done = 1'b0; dma_conflict = 1'b0; dma_buserr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int k = 0; k < 8; k++) begin
            rd(BASE + 10'(k), r);
            chk("R1 reg after reset", 32'(r), 32'h0);
        end
        chk("R1 reset outputs", {27'b0, fifo_rst_n, scsi_rst_n, dma_en, dir_send, irq}, 32'h0);
        chk("R1 wide outputs", dma_addr | dma_count | fifo_count, 32'h0);

        // R2: active-low reset bits
        wr(BASE, 16'h0001);
        chk("R2 fifo released", {30'b0, fifo_rst_n, scsi_rst_n}, 32'h2);
        wr(BASE, 16'h0002);
        chk("R2 scsi released", {30'b0, fifo_rst_n, scsi_rst_n}, 32'h1);
        wr(BASE, 16'h0000);
        chk("R2 both held", {30'b0, fifo_rst_n, scsi_rst_n}, 32'h0);

        // R3: split wide registers, several patterns per pair
        for (int p = 0; p < 3; p++) begin
            for (int n = 0; n < 4; n++) begin
                logic [31:0] v;
                logic [31:0] outv;
                v = 32'h1357_9BDF ^ (32'h1111_1111 * (n + 1)) ^ (32'(p) << 28);
                wr(BASE + 10'(1 + 2 * p), v[31:16]);
                wr(BASE + 10'(2 + 2 * p), v[15:0]);
                outv = (p == 0) ? dma_addr : (p == 1) ? dma_count : fifo_count;
                chk("R3 wide output", outv, v);
                rd(BASE + 10'(1 + 2 * p), r);
                chk("R3 high readback", 32'(r), 32'(v[31:16]));
                rd(BASE + 10'(2 + 2 * p), r);
                chk("R3 low readback", 32'(r), 32'(v[15:0]));
            end
        end

        // R4: FIFO count writes clear the DMA count
        wr(BASE + 10'd3, 16'h1234);
        wr(BASE + 10'd4, 16'h5678);
        chk("R4 dcnt loaded", dma_count, 32'h1234_5678);
        wr(BASE + 10'd5, 16'h0001);
        chk("R4 dcnt cleared by fcnt hi", dma_count, 32'h0);
        chk("R4 fcnt hi stored", 32'(fifo_count[31:16]), 32'h1);
        wr(BASE + 10'd4, 16'h00AA);
        wr(BASE + 10'd6, 16'h0000);
        chk("R4 dcnt cleared by fcnt lo", dma_count, 32'h0);
        wr(BASE + 10'd5, 16'h0000);

        // R5 / R6: controller window with DMA off and on
        for (int de = 0; de < 2; de++) begin
            wr(BASE, 16'h0003 | 16'(de << 3));
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                host_req = 1'b1; host_we = 1'b1; host_addr = 10'(k);
                host_wdata = 16'hC030 + 16'(k);
                #1;
                if (de == 0) begin
                    chk("R5 write forwarded", {chip_sel, chip_we, 1'b0, chip_addr, chip_wdata},
                        {1'b1, 1'b1, 1'b0, 3'(k), 8'h30 + 8'(k)});
                end else begin
                    chk("R6 write blocked", {30'b0, chip_sel, chip_we}, 32'h0);
                end
                host_we = 1'b0;
                chip_rdata = 8'h5A ^ 8'(k);
                #1;
                if (de == 0) chk("R5 read data", 32'(host_rdata), 32'(8'h5A ^ 8'(k)));
                else chk("R6 read blocked", {15'b0, chip_sel, host_rdata}, 32'h0);
                host_req = 1'b0;
            end
        end

        // R7: status field is read-only
        wr(BASE, 16'h0000);
        wr(BASE, 16'h0F03);
        rd(BASE, r);
        chk("R7 status ignores writes", 32'(r), 32'h0003);

        // R8: sticky errors fold into DMA pending
        pulse(1);
        rd(BASE, r);
        chk("R8 conflict sets bits 9 and 10", 32'(r), 32'h0603);
        pulse(2);
        rd(BASE, r);
        chk("R8 bus error sets bit 11", 32'(r), 32'h0E03);
        chk("R11 irq disabled", 32'(irq), 32'h0);
        wr(BASE, 16'h0F07);
        chk("R11 irq from error", 32'(irq), 32'h1);
        rd(BASE, r);
        chk("R7 status unchanged by write", 32'(r), 32'h0E07);

        // R9: FIFO reset clears flags and masks events
        wr(BASE, 16'h0002);
        rd(BASE, r);
        chk("R9 flags cleared", 32'(r), 32'h0002);
        pulse(0);
        pulse(1);
        pulse(2);
        wr(BASE, 16'h0003);
        rd(BASE, r);
        chk("R9 events ignored in reset", 32'(r), 32'h0003);

        // R12: direction and vector word
        wr(BASE, 16'h0013);
        chk("R12 dir_send", 32'(dir_send), 32'h1);
        wr(BASE + 10'd7, 16'hBEEF);
        rd(BASE + 10'd7, r);
        chk("R12 vector readback", {16'(r), vec_am}, 32'hBEEF_BEEF);

        // R10 / R11: all 64 combinations of the interrupt inputs
        for (int c = 0; c < 64; c++) begin
            logic ie, de, ci, fne, fcz, dp, cp, exp_irq;
            {ie, de, ci, fne, fcz, dp} = 6'(c);
            cp = ci & !fne & !fcz;
            exp_irq = ie & (dp | (de & cp));
            wr(BASE, 16'h0000);
            wr(BASE, 16'h0003);
            if (dp) pulse(0);
            wr(BASE + 10'd6, {15'b0, fcz});
            @(negedge clk);
            fifo_not_empty = fne;
            chip_irq = ci;
            wr(BASE, 16'h0003 | 16'({ie, 2'b00}) | 16'({de, 3'b000}));
            #1;
            chk("R11 irq combination", {26'b0, 6'(c), irq}, {26'b0, 6'(c), exp_irq});
            rd(BASE, r);
            chk("R10 status pending bits", {26'b0, 6'(c), r[9:8]}, {26'b0, 6'(c), dp, cp});
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule